// File: doc/BRIEF.md
# Multi-Channel Temperature Threshold Interrupt Controller

This block watches the readings of several on-die temperature channels. Each channel has its own lower, upper and critical limit. When the sensor front end delivers a new reading for a channel, the block compares it against that channel's three limits and updates three violation flags. Each flag has its own mask bit and its own clear bit. The flags from all channels combine into two level-sensitive interrupt lines. One line serves lower and upper crossings. The other serves critical crossings and a watchdog-bark event.

Software reaches every setting through a plain register port with a one-cycle write and a combinational read. Through that port it sets limits and masks, pulses clears, sets the global interrupt-enable field, and reads back violation flags and the latest reading. The latest reading has a valid flag. That flag reads low for a short fixed window after each new sample, and software should not use the reading while it is low.

Readings and limits are signed, in steps of 0.1 °C. Software keeps the limits inside −40.0 °C to 120.0 °C.

Top module: `tmon_irq_ctrl`

## Requirements
- R1: After reset, these are the register values: every mask bit is 1, the enable field is 0, all flags and clear bits are 0, every valid flag is 1, and every latest reading is 0. Every lower limit holds the most negative code and every upper and critical limit holds the most positive code. The bark mask is 1, the bark count is 0, and both interrupt lines are low.
- R2: A sample updates only the addressed channel's flags. Bit 1 (upper) is set when reading ≥ upper limit, bit 0 (lower) when reading ≤ lower limit, and bit 2 (critical) when reading ≥ critical limit. All comparisons are signed. With no sample, a flag holds its value.
- R3: The register address is {0, channel[3:0], field[2:0]}. The fields are 0 lower limit, 1 upper limit, 2 critical limit, 3 mask, 4 clear, 5 flags (read-only) and 6 latest reading (read-only). Limits read back sign-extended to 32 bits. Address 0x80 is the enable field, 0x81 the bark control and 0x82 the bark count.
- R4: The mask bits (bit 0 lower, bit 1 upper, bit 2 critical) only block a flag's path to its interrupt line. A flag still sets and reads back while it is masked. Writing 0 to a mask bit unmasks it.
- R5: While a clear bit is 1, its flag reads 0 and no sample can set it. The flag drops at the same edge that writes the 1. Writing the clear bit back to 0 re-arms the flag for the next sample.
- R6: Enable bit 0 gates lower flags and bit 1 gates upper flags on the up/low line. Bit 2 gates critical flags on the critical line.
- R7: The up/low line is the OR over all channels of enabled, unmasked upper and lower flags.
- R8: The critical line is high when any channel has an enabled, unmasked critical flag, or when the bark flag is set and unmasked.
- R9: A sample drops that channel's valid flag for exactly 6 cycles after the sampling edge. The new value is visible at once.
- R10: The latest-reading register holds the reading sign-extended to 16 bits in bits 15:0, with valid in bit 16.
- R11: A bark event sets the bark flag and increments a saturating bark count. Bark control is written as bit 0 mask and bit 1 clear, and reads as bit 0 mask, bit 1 clear and bit 2 flag. The clear works as in R5. The bark path is not gated by the enable field.
- R12: Both interrupt lines are level outputs. They fall without any clear when a new in-range sample arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | A new reading is presented this cycle |
| smp_ch | input | CH_W | Channel that the reading belongs to |
| smp_val | input | TEMP_W | Signed reading in 0.1 °C |
| bark_evt | input | 1 | Watchdog-bark event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_uplow | output | 1 | Level interrupt for upper and lower crossings |
| irq_crit | output | 1 | Level interrupt for critical crossings and bark |

## Verification
The bench places readings exactly on each limit and one code past it, including negative ones:
- An off-by-one comparison misreports the flag at the limit itself.
- An unsigned comparison raises the upper flag for a reading of −100.

The valid flag is read on the last low cycle and on the first high cycle, so a window that is one cycle short or long shows up. A sample is sent while a clear is held. The flags are read back after masking to show that a mask hides only the interrupt. A sample on another channel checks that the first channel's flags stay put. The bark line is driven with the enable field at 0 to show that it is not gated.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    typedef enum logic [2:0] {
        F_LOW  = 3'd0,
        F_UP   = 3'd1,
        F_CRIT = 3'd2,
        F_MASK = 3'd3,
        F_CLR  = 3'd4,
        F_STAT = 3'd5,
        F_LAST = 3'd6
    } field_e;

    localparam logic [2:0] G_EN   = 3'd0;
    localparam logic [2:0] G_BARK = 3'd1;
    localparam logic [2:0] G_BCNT = 3'd2;

    localparam int KIND_LOW  = 0;
    localparam int KIND_UP   = 1;
    localparam int KIND_CRIT = 2;
endpackage

// File: rtl/tmon_channel.sv
module tmon_channel
    import tmon_pkg::*;
#(
    parameter int TEMP_W = 12,
    parameter int HOLD   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_field,
    input  logic [TEMP_W-1:0] cfg_wdata,
    input  logic              smp_en,
    input  logic [TEMP_W-1:0] smp_val,
    output logic [TEMP_W-1:0] thr_lo_o,
    output logic [TEMP_W-1:0] thr_up_o,
    output logic [TEMP_W-1:0] thr_cr_o,
    output logic [2:0]        mask_o,
    output logic [2:0]        clr_o,
    output logic [2:0]        stat_o,
    output logic [TEMP_W-1:0] last_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};
    localparam logic [TEMP_W-1:0] T_MAX = {1'b0, {(TEMP_W-1){1'b1}}};

    typedef struct packed {
        logic [TEMP_W-1:0] lo;
        logic [TEMP_W-1:0] up;
        logic [TEMP_W-1:0] cr;
        logic [TEMP_W-1:0] last;
        logic [2:0]        mask;
        logic [2:0]        clr;
        logic [2:0]        stat;
        logic [CNT_W-1:0]  cnt;
    } ch_t;

    ch_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) begin
            case (cfg_field)
                F_LOW:   d.lo   = cfg_wdata;
                F_UP:    d.up   = cfg_wdata;
                F_CRIT:  d.cr   = cfg_wdata;
                F_MASK:  d.mask = cfg_wdata[2:0];
                F_CLR:   d.clr  = cfg_wdata[2:0];
                default: ;
            endcase
        end
        if (smp_en) begin
            d.last = smp_val;
            d.cnt  = CNT_W'(HOLD);
            d.stat[KIND_LOW]  = $signed(smp_val) <= $signed(q.lo);
            d.stat[KIND_UP]   = $signed(smp_val) >= $signed(q.up);
            d.stat[KIND_CRIT] = $signed(smp_val) >= $signed(q.cr);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
        d.stat = d.stat & ~d.clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lo   <= T_MIN;
            q.up   <= T_MAX;
            q.cr   <= T_MAX;
            q.last <= '0;
            q.mask <= 3'b111;
            q.clr  <= 3'b000;
            q.stat <= 3'b000;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign thr_lo_o = q.lo;
    assign thr_up_o = q.up;
    assign thr_cr_o = q.cr;
    assign mask_o   = q.mask;
    assign clr_o    = q.clr;
    assign stat_o   = q.stat;
    assign last_o   = q.last;
    assign valid_o  = (q.cnt == '0);

    // R2
    up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en && ($signed(smp_val) >= $signed(thr_up_o)) && !clr_o[1]
        && !(cfg_we && cfg_field == F_CLR) |=> stat_o[1]);

    // R2
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en && !(cfg_we && cfg_field == F_CLR) |=> $stable(stat_o));

    // R5
    clr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o[0] |-> !stat_o[0]);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |=> !valid_o);
endmodule

// File: rtl/tmon_bark.sv
module tmon_bark #(
    parameter int BARK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bark_evt,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic              mask_o,
    output logic              clr_o,
    output logic              stat_o,
    output logic [BARK_W-1:0] cnt_o
);
    typedef struct packed {
        logic              mask;
        logic              clr;
        logic              stat;
        logic [BARK_W-1:0] cnt;
    } bark_t;

    bark_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) begin
            d.mask = cfg_wdata[0];
            d.clr  = cfg_wdata[1];
        end
        if (bark_evt) begin
            d.stat = 1'b1;
            if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
        end
        d.stat = d.stat & ~d.clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mask <= 1'b1;
            q.clr  <= 1'b0;
            q.stat <= 1'b0;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign mask_o = q.mask;
    assign clr_o  = q.clr;
    assign stat_o = q.stat;
    assign cnt_o  = q.cnt;

    // R11
    bark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bark_evt && !clr_o && !(cfg_we && cfg_wdata[1]) |=> stat_o);

    // R11
    bark_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bark_evt && (cnt_o != '1) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/tmon_irq_ctrl.sv
module tmon_irq_ctrl
    import tmon_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int TEMP_W     = 12,
    parameter int VALID_HOLD = 6,
    parameter int BARK_W     = 8,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [TEMP_W-1:0] smp_val,
    input  logic              bark_evt,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_uplow,
    output logic              irq_crit
);
    logic              is_glob;
    logic [3:0]        ch_sel;
    logic [2:0]        field;
    logic [2:0]        en_d, en_q;
    logic              unused_wd;

    logic [TEMP_W-1:0] lo_a   [NUM_CH];
    logic [TEMP_W-1:0] up_a   [NUM_CH];
    logic [TEMP_W-1:0] cr_a   [NUM_CH];
    logic [TEMP_W-1:0] last_a [NUM_CH];
    logic [2:0]        mask_a [NUM_CH];
    logic [2:0]        clr_a  [NUM_CH];
    logic [2:0]        stat_a [NUM_CH];
    logic              vld_a  [NUM_CH];

    logic              bk_mask, bk_clr, bk_stat;
    logic [BARK_W-1:0] bk_cnt;
    logic              any_up, any_lo, any_cr;

    assign is_glob   = reg_addr[7];
    assign ch_sel    = reg_addr[6:3];
    assign field     = reg_addr[2:0];
    assign unused_wd = ^reg_wdata[31:TEMP_W];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmon_channel #(.TEMP_W(TEMP_W), .HOLD(VALID_HOLD)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (reg_we && !is_glob && (ch_sel == 4'(g))),
            .cfg_field (field),
            .cfg_wdata (reg_wdata[TEMP_W-1:0]),
            .smp_en    (smp_en && (smp_ch == CH_W'(g))),
            .smp_val   (smp_val),
            .thr_lo_o  (lo_a[g]),
            .thr_up_o  (up_a[g]),
            .thr_cr_o  (cr_a[g]),
            .mask_o    (mask_a[g]),
            .clr_o     (clr_a[g]),
            .stat_o    (stat_a[g]),
            .last_o    (last_a[g]),
            .valid_o   (vld_a[g])
        );
    end

    tmon_bark #(.BARK_W(BARK_W)) u_bark (
        .clk       (clk),
        .rst_n     (rst_n),
        .bark_evt  (bark_evt),
        .cfg_we    (reg_we && is_glob && (field == G_BARK)),
        .cfg_wdata (reg_wdata[1:0]),
        .mask_o    (bk_mask),
        .clr_o     (bk_clr),
        .stat_o    (bk_stat),
        .cnt_o     (bk_cnt)
    );

    always_comb begin
        en_d = en_q;
        if (reg_we && is_glob && (field == G_EN)) en_d = reg_wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 3'b000;
        else        en_q <= en_d;
    end

    always_comb begin
        any_up = 1'b0;
        any_lo = 1'b0;
        any_cr = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            any_lo = any_lo | (stat_a[i][KIND_LOW]  & ~mask_a[i][KIND_LOW]);
            any_up = any_up | (stat_a[i][KIND_UP]   & ~mask_a[i][KIND_UP]);
            any_cr = any_cr | (stat_a[i][KIND_CRIT] & ~mask_a[i][KIND_CRIT]);
        end
    end

    assign irq_uplow = (en_q[KIND_LOW] & any_lo) | (en_q[KIND_UP] & any_up);
    assign irq_crit  = (en_q[KIND_CRIT] & any_cr) | (bk_stat & ~bk_mask);

    always_comb begin
        reg_rdata = '0;
        if (is_glob) begin
            case (field)
                G_EN:    reg_rdata = {29'b0, en_q};
                G_BARK:  reg_rdata = {29'b0, bk_stat, bk_clr, bk_mask};
                G_BCNT:  reg_rdata = 32'(bk_cnt);
                default: reg_rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == 4'(i)) begin
                    case (field)
                        F_LOW:  reg_rdata = {{(32-TEMP_W){lo_a[i][TEMP_W-1]}}, lo_a[i]};
                        F_UP:   reg_rdata = {{(32-TEMP_W){up_a[i][TEMP_W-1]}}, up_a[i]};
                        F_CRIT: reg_rdata = {{(32-TEMP_W){cr_a[i][TEMP_W-1]}}, cr_a[i]};
                        F_MASK: reg_rdata = {29'b0, mask_a[i]};
                        F_CLR:  reg_rdata = {29'b0, clr_a[i]};
                        F_STAT: reg_rdata = {29'b0, stat_a[i]};
                        F_LAST: reg_rdata = {15'b0, vld_a[i],
                                             {(16-TEMP_W){last_a[i][TEMP_W-1]}}, last_a[i]};
                        default: reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[1:0] == 2'b00) |-> !irq_uplow);

    // R8
    bark_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_stat && !bk_mask) |-> irq_crit);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_uplow && !irq_crit);
endmodule

// File: tb/tb_tmon_irq_ctrl.sv
`timescale 1ns/1ps
module tb_tmon_irq_ctrl;
    localparam int NUM_CH = 4;
    localparam int TEMP_W = 12;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_en = 1'b0;
    logic [CH_W-1:0]   smp_ch = '0;
    logic [TEMP_W-1:0] smp_val = '0;
    logic              bark_evt = 1'b0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_uplow, irq_crit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    tmon_irq_ctrl #(.NUM_CH(NUM_CH), .TEMP_W(TEMP_W)) dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_ch(smp_ch),
        .smp_val(smp_val), .bark_evt(bark_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_uplow(irq_uplow), .irq_crit(irq_crit)
    );

    function automatic logic [7:0] ca(input int c, input int f);
        return {1'b0, 4'(c), 3'(f)};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic smp(input int c, input int v);
        smp_en = 1'b1; smp_ch = CH_W'(c); smp_val = TEMP_W'(v);
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic bark();
        bark_evt = 1'b1;
        @(negedge clk);
        bark_evt = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        item_t it;
        reg_addr = a;
        it.kind = 0; it.exp = e; it.tag = t;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic irq(input logic eu, input logic ec, input string t);
        item_t it;
        it.kind = 1; it.exp = {31'b0, eu}; it.tag = t;
        sb.push_back(it);
        it.kind = 2; it.exp = {31'b0, ec}; it.tag = t;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares queued expectations mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? reg_rdata :
                      (it.kind == 1) ? {31'b0, irq_uplow} : {31'b0, irq_crit};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(ca(0,3), 32'h7, "R1 mask");
        rd(8'h80, 32'h0, "R1 enable");
        rd(ca(0,5), 32'h0, "R1 flags");
        rd(ca(0,6), 32'h0001_0000, "R1 latest");
        rd(ca(0,0), 32'hFFFF_F800, "R1 low limit");
        rd(ca(0,1), 32'h0000_07FF, "R1 up limit");
        rd(8'h81, 32'h1, "R1 bark ctrl");
        rd(8'h82, 32'h0, "R1 bark count");
        irq(0, 0, "R1 lines");

        // R3 programming and readback
        wr(ca(0,0), 32'hFFFF_FF9C);
        wr(ca(0,1), 32'd800);
        wr(ca(0,2), 32'd1100);
        wr(ca(1,0), 32'd0);
        wr(ca(1,1), 32'd300);
        rd(ca(0,0), 32'hFFFF_FF9C, "R3 low");
        rd(ca(0,1), 32'd800, "R3 up");
        rd(ca(0,2), 32'd1100, "R3 crit");
        wr(8'h80, 32'd7);
        wr(ca(0,3), 32'd0);
        rd(8'h80, 32'd7, "R3 enable");

        // R9 valid window
        smp(0, 500);
        rd(ca(0,6), 32'h0000_01F4, "R9 first low cycle");
        idle(4);
        rd(ca(0,6), 32'h0000_01F4, "R9 last low cycle");
        rd(ca(0,6), 32'h0001_01F4, "R9 valid again");
        rd(ca(0,5), 32'h0, "R2 in range");
        irq(0, 0, "R2 in range");

        // R2 boundaries
        smp(0, 800);
        rd(ca(0,5), 32'h2, "R2 equal upper");
        irq(1, 0, "R7 upper");
        smp(0, 500);
        rd(ca(0,5), 32'h0, "R12 back in range");
        irq(0, 0, "R12 level");
        smp(0, -100);
        rd(ca(0,5), 32'h1, "R2 equal lower signed");
        irq(1, 0, "R7 lower");
        idle(6);
        rd(ca(0,6), 32'h0001_FF9C, "R10 sign extend");
        smp(0, -99);
        rd(ca(0,5), 32'h0, "R2 above lower");
        smp(0, 1100);
        rd(ca(0,5), 32'h6, "R2 crit and up");
        irq(1, 1, "R8 crit");

        // R4 masks
        wr(ca(0,3), 32'd6);
        rd(ca(0,5), 32'h6, "R4 flags kept");
        irq(0, 0, "R4 masked");

        // R6 global enable
        wr(ca(0,3), 32'd0);
        wr(8'h80, 32'd4);
        irq(0, 1, "R6 crit only");
        wr(8'h80, 32'd3);
        irq(1, 0, "R6 uplow only");
        wr(8'h80, 32'd7);

        // R5 clear
        wr(ca(0,4), 32'd7);
        rd(ca(0,5), 32'h0, "R5 clear drops");
        irq(0, 0, "R5 lines");
        smp(0, 1100);
        rd(ca(0,5), 32'h0, "R5 blocked");
        wr(ca(0,4), 32'd0);
        rd(ca(0,5), 32'h0, "R5 release");
        rd(ca(0,4), 32'h0, "R5 clear readback");
        smp(0, 1100);
        rd(ca(0,5), 32'h6, "R5 rearmed");

        // R2 channel isolation
        smp(1, 250);
        rd(ca(0,5), 32'h6, "R2 other channel");
        rd(ca(1,5), 32'h0, "R2 ch1 in range");
        wr(ca(0,4), 32'd7);
        wr(ca(0,4), 32'd0);
        irq(0, 0, "R5 ch0 cleared");

        // R7 OR across channels
        smp(1, 300);
        rd(ca(1,5), 32'h2, "R4 ch1 flag while masked");
        irq(0, 0, "R4 ch1 masked");
        wr(ca(1,3), 32'd0);
        irq(1, 0, "R7 ch1");
        smp(1, 100);
        irq(0, 0, "R12 ch1");

        // R11 bark
        bark();
        rd(8'h81, 32'h5, "R11 flag set");
        rd(8'h82, 32'd1, "R11 count");
        irq(0, 0, "R11 masked");
        wr(8'h81, 32'd0);
        irq(0, 1, "R11 unmasked");
        wr(8'h80, 32'd0);
        irq(0, 1, "R11 not gated");
        wr(8'h80, 32'd7);
        bark();
        rd(8'h82, 32'd2, "R11 count2");
        wr(8'h81, 32'd2);
        rd(8'h81, 32'h2, "R11 clear");
        irq(0, 0, "R11 cleared");
        bark();
        rd(8'h81, 32'h2, "R11 blocked");
        rd(8'h82, 32'd3, "R11 count3");
        wr(8'h81, 32'd0);
        rd(8'h81, 32'h0, "R11 released");
        bark();
        rd(8'h81, 32'h4, "R11 rearmed");
        irq(0, 1, "R11 line");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule